// File: doc/BRIEF.md
# Pipeline Hazard and Branch-Shadow Squash Controller

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, writeback) resolves its hazards. All instruction classes write the register file only in the fifth stage, so arithmetic results pass the memory stage idle and never contend with loads for the one write port. The register file writes early in a cycle and reads late, so a consumer three slots behind its producer reads the fresh value directly. Closer consumers get the value steered into the ALU operands from the pipeline registers.

When a load in execute feeds the very next instruction, steering cannot bridge the gap. The controller then freezes fetch and decode for one cycle and injects an empty slot into execute. Branches resolve in execute with one architectural delay slot that always completes. On a taken branch, the instruction fetched just after the slot is killed. The controller flags it so that the fetch/decode register becomes an empty slot on the next edge, and that instruction can then neither write a register nor raise overflow. The datapath itself is outside the block; only the control decisions and their ordering are built here.

Top module: `hzd_ctrl`

## Requirements
- R1: An ALU operand select reads 2'b10 (take the memory-stage result) when the memory-stage instruction writes, its destination is nonzero and equals that operand's source register in execute.
- R2: An ALU operand select reads 2'b01 (take the writeback-stage result) when the writeback-stage instruction writes a nonzero destination equal to that source and the memory stage does not match.
- R3: An operand select reads 2'b00 (use the register-file value) when neither stage matches; register 0 never matches even when a stage writes register 0.
- R4: When both the memory and the writeback stage match the same source, the memory-stage result (2'b10) is chosen.
- R5: `stall` is high exactly when the execute instruction is a load that writes a nonzero destination equal to either source register of the decode instruction; a matching non-load never stalls.
- R6: `bubble` is high in exactly the cycles where `stall` is high.
- R7: A taken branch in a cycle without a stall raises `squash` in that same cycle.
- R8: A taken branch in a stalled cycle leaves `squash` low during the stall and raises it in the first following cycle without a stall; `squash` and `stall` are never high together.
- R9: Reset clears any deferred squash: after reset `squash` stays low until a new taken branch arrives.
- R10: With no taken branch and nothing deferred, `squash` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | AW | First source register of the decode instruction |
| id_rs2 | input | AW | Second source register of the decode instruction |
| ex_rs1 | input | AW | First source register of the execute instruction |
| ex_rs2 | input | AW | Second source register of the execute instruction |
| ex_rd | input | AW | Destination of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | AW | Destination of the writeback instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| ex_br_taken | input | 1 | Branch in execute resolved taken |
| fwd_a | output | 2 | Operand A select (00 file, 01 writeback, 10 memory) |
| fwd_b | output | 2 | Operand B select, same encoding |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Load empty control into decode/execute register |
| squash | output | 1 | Turn the fetch/decode entry into an empty slot at next edge |

## Verification
The two functions that can meet in one cycle are the load-use stall and the taken-branch squash request. The bench drives a taken branch together with a matching load in execute, both in directed cases (a single stalled cycle, and several stalled cycles in a row before release) and in random traffic with small register numbers so matches are frequent. It judges that `squash` stays low while frozen, appears on the first unfrozen cycle exactly once, and is never lost or duplicated, against a bench model that tracks the deferred request.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic pend;
    } shadow_st_t;
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
    parameter int AW = 5
) (
    input  logic [AW-1:0]    src,
    input  logic [AW-1:0]    mem_rd,
    input  logic             mem_we,
    input  logic [AW-1:0]    wb_rd,
    input  logic             wb_we,
    output hzd_pkg::fwd_sel_e sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
        if (mem_hit)      sel = hzd_pkg::FWD_MEM;
        else if (wb_hit)  sel = hzd_pkg::FWD_WB;
        else              sel = hzd_pkg::FWD_RF;
    end
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic [NSRC*AW-1:0] srcs,
    input  logic [AW-1:0]      ex_rd,
    input  logic               ex_we,
    input  logic               ex_load,
    output logic               hit
);
    logic [NSRC-1:0] src_hit;
    logic            producer_ok;

    assign producer_ok = ex_load && ex_we && (ex_rd != '0);

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        assign src_hit[gi] = (srcs[gi*AW +: AW] == ex_rd);
    end

    assign hit = producer_ok && (|src_hit);
endmodule

// File: rtl/hzd_shadow.sv
module hzd_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic br_taken,
    input  logic stall,
    output logic squash
);
    import hzd_pkg::*;

    shadow_st_t st_d, st_q;
    logic       req;

    always_comb begin
        req     = br_taken || st_q.pend;
        squash  = req && !stall;
        st_d    = st_q;
        st_d.pend = req && stall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_we,
    input  logic          ex_br_taken,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          stall,
    output logic          bubble,
    output logic          squash
);
    localparam int NOPS = 2;

    logic [NOPS*AW-1:0]  ex_srcs;
    logic [NOPS*AW-1:0]  id_srcs;
    hzd_pkg::fwd_sel_e   sel [NOPS];
    logic                lu_hit;

    assign ex_srcs = {ex_rs2, ex_rs1};
    assign id_srcs = {id_rs2, id_rs1};

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_op
        hzd_fwd_sel #(.AW(AW)) u_fwd (
            .src    (ex_srcs[gi*AW +: AW]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel[gi])
        );
    end

    hzd_loaduse #(.AW(AW), .NSRC(NOPS)) u_lu (
        .srcs    (id_srcs),
        .ex_rd   (ex_rd),
        .ex_we   (ex_we),
        .ex_load (ex_load),
        .hit     (lu_hit)
    );

    hzd_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_taken (ex_br_taken),
        .stall    (lu_hit),
        .squash   (squash)
    );

    assign fwd_a  = sel[0];
    assign fwd_b  = sel[1];
    assign stall  = lu_hit;
    assign bubble = lu_hit;
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ex_rs1,
    input logic [AW-1:0] ex_rd,
    input logic          ex_load,
    input logic [AW-1:0] mem_rd,
    input logic          mem_we,
    input logic          ex_br_taken,
    input logic [1:0]    fwd_a,
    input logic          stall,
    input logic          bubble,
    input logic          squash
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r1_mem_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rd != '0 && mem_rd == ex_rs1) |-> (fwd_a == 2'b10));

    a_r3_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b00) |-> (ex_rs1 != '0));

    a_r5_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_load && ex_rd != '0));

    a_r6_bubble_with_stall: assert property (@(posedge clk) disable iff (!rst_n)
        bubble == stall);

    a_r7_taken_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_br_taken && !stall) |-> squash);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && squash));

    a_r8_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(ex_br_taken && stall) && !stall) |-> squash);
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_rs1      (ex_rs1),
    .ex_rd       (ex_rd),
    .ex_load     (ex_load),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .ex_br_taken (ex_br_taken),
    .fwd_a       (fwd_a),
    .stall       (stall),
    .bubble      (bubble),
    .squash      (squash)
);

// File: tb/hzd_ctrl_test.sv
`timescale 1ns/1ps
module hzd_ctrl_test;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic          ex_we, ex_load, mem_we, wb_we, ex_br_taken;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall, bubble, squash;

    int errs   = 0;
    int checks = 0;
    bit mpend  = 1'b0;

    always #2.5 clk = ~clk;

    hzd_ctrl #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_we(mem_we),
        .wb_rd(wb_rd), .wb_we(wb_we),
        .ex_br_taken(ex_br_taken),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .stall(stall), .bubble(bubble), .squash(squash)
    );

    function automatic logic [1:0] exp_fwd(logic [AW-1:0] s);
        if (mem_we && mem_rd != 0 && mem_rd == s) return 2'b10;
        if (wb_we && wb_rd != 0 && wb_rd == s)    return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_stall();
        return ex_load && ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string ftag(logic [1:0] e);
        if (e == 2'b10) return "R1";
        if (e == 2'b01) return "R2";
        return "R3";
    endfunction

    task automatic idle();
        id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        mem_rd = 0; wb_rd = 0; ex_we = 0; ex_load = 0;
        mem_we = 0; wb_we = 0; ex_br_taken = 0;
    endtask

    // sample one cycle: inputs already set after a negedge; check then update model
    task automatic judge();
        logic       es;
        logic       req;
        logic [1:0] ea, eb;
        #1;
        ea  = exp_fwd(ex_rs1);
        eb  = exp_fwd(ex_rs2);
        es  = exp_stall();
        req = ex_br_taken || mpend;
        chk(ftag(ea), fwd_a, ea);
        chk(ftag(eb), fwd_b, eb);
        chk("R5 stall", stall, es);
        chk("R6 bubble", bubble, es);
        if (ex_br_taken && !es)      chk("R7 squash", squash, 1);
        else if (req)                chk("R8 squash", squash, !es);
        else                         chk("R10 squash", squash, 0);
        mpend = req && es;
    endtask

    initial begin
        #(5.0 * 200000);
        errs++; checks++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset squash", squash, 0);
        chk("R9 reset stall", stall, 0);
        chk("R3 reset fwd_a", fwd_a, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 memory stage match on operand A
        @(negedge clk); idle(); ex_rs1 = 5; mem_rd = 5; mem_we = 1; judge();
        // R2 writeback match on operand B
        @(negedge clk); idle(); ex_rs2 = 7; wb_rd = 7; wb_we = 1; judge();
        // R4 both match, memory wins
        @(negedge clk); idle(); ex_rs1 = 9; ex_rs2 = 9; mem_rd = 9; mem_we = 1;
        wb_rd = 9; wb_we = 1; #1;
        chk("R4 fwd_a priority", fwd_a, 2); chk("R4 fwd_b priority", fwd_b, 2);
        // R3 register 0 never matches
        @(negedge clk); idle(); mem_we = 1; wb_we = 1; judge();
        // R3 write disabled does not match
        @(negedge clk); idle(); ex_rs1 = 4; mem_rd = 4; wb_rd = 4; judge();
        // R5 load-use on second source
        @(negedge clk); idle(); ex_load = 1; ex_we = 1; ex_rd = 3; id_rs2 = 3; judge();
        // R5 non-load match does not stall
        @(negedge clk); idle(); ex_we = 1; ex_rd = 3; id_rs1 = 3; judge();
        // R5 load to register 0 does not stall
        @(negedge clk); idle(); ex_load = 1; ex_we = 1; id_rs1 = 0; judge();
        // R7 taken branch alone
        @(negedge clk); idle(); ex_br_taken = 1; judge();
        @(negedge clk); idle(); judge();
        // R8 taken branch during one stalled cycle, then release
        @(negedge clk); idle(); ex_br_taken = 1; ex_load = 1; ex_we = 1; ex_rd = 6; id_rs1 = 6;
        judge();
        @(negedge clk); idle(); judge();
        @(negedge clk); judge();
        // R8 several stalled cycles before release
        @(negedge clk); idle(); ex_br_taken = 1; ex_load = 1; ex_we = 1; ex_rd = 2; id_rs2 = 2;
        judge();
        @(negedge clk); ex_br_taken = 0; judge();
        @(negedge clk); judge();
        @(negedge clk); idle(); judge();
        @(negedge clk); judge();
        // R9 reset clears a deferred squash
        @(negedge clk); idle(); ex_br_taken = 1; ex_load = 1; ex_we = 1; ex_rd = 1; id_rs1 = 1;
        judge();
        @(negedge clk); idle(); rst_n = 1'b0; #1; mpend = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); idle(); #1;
        chk("R9 squash after reset", squash, 0);

        // constrained random traffic, small register numbers
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
            ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
            ex_rd  = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
            wb_rd  = AW'($urandom_range(0, 3));
            ex_we  = 1'($urandom_range(0, 1)); ex_load = 1'($urandom_range(0, 1));
            mem_we = 1'($urandom_range(0, 1)); wb_we = 1'($urandom_range(0, 1));
            ex_br_taken = ($urandom_range(0, 3) == 0);
            judge();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule